// File: doc/BRIEF.md
# Branch Resolution Unit

This block resolves the branch instructions of a small 8-bit accumulator processor. When `start` is high, it samples the opcode and everything that opcode needs on that clock edge. This includes an optional stack-form prefix flag, the condition flags, the level of the external interrupt-request pin, an 8-bit signed displacement, the program counter, both data registers, and a memory or immediate operand byte. From these it decides whether the branch is taken. It also produces the next program counter, the fall-through (return) address and the cycle cost of the instruction.

The block handles three families of instructions:
- conditional relative branches, selected by flags or by the interrupt pin;
- bit-test branches on a byte, with the bit index taken from the opcode;
- compare-and-branch-if-equal in several addressing forms, plus branch-to-subroutine.

A cycle counter is loaded with the cost of the instruction. When it runs out, `done` pulses for one clock. The results stay on the outputs until the next `start`. Any opcode the block does not own raises `foreign` instead.

Top module: `branch_resolve`

## Requirements
- R1: Relative branch conditions (`prefix_sp`=0) are decided as follows:
  - 0x20 always; 0x21 never;
  - 0x23 when C or Z; 0x24 when C=0; 0x25 when C=1; 0x26 when Z=0;
  - 0x2A when N=0; 0x2B when N=1;
  - 0x2C when I=0; 0x2D when I=1;
  - 0x2E when `irq_level`=0; 0x2F when `irq_level`=1;
  - 0x91 when N xor V; 0x93 when Z or (N xor V).
- R2: For a relative branch, `next_pc` is PC+2+sign-extended(`rel_off`) when taken and PC+2 otherwise. The addition wraps modulo 65536, and `cycle_count` is 3.
- R3: Opcodes 0x00..0x0F test bit n = opcode[3:1] of `mem_byte`. An even opcode is taken when the bit is 1 and an odd opcode when it is 0. The step is 3 and the cost is 5 cycles.
- R4: Compare-and-branch is taken when the register equals `mem_byte`. 0x51 compares `reg_x` and every other compare opcode compares `reg_a`. The step and cycle cost for each opcode are: 0x31 step 3, 5 cycles; 0x41 step 3, 4 cycles; 0x51 step 3, 4 cycles; 0x61 step 3, 5 cycles; 0x71 step 2, 4 cycles.
- R5: With `prefix_sp`=1, opcode 0x61 is the stack-relative compare with step 4 and a cost of 6 cycles. With `prefix_sp`=1, every other opcode is foreign.
- R6: 0xAD is always taken, with target PC+2+offset and a cost of 4 cycles. For every owned opcode, `ret_addr` is PC+step, so for 0xAD it is PC+2.
- R7: A foreign opcode gives `foreign`=1, `taken`=0, `next_pc`=PC and `cycle_count`=1.
- R8: `done` rises exactly `cycle_count` clocks after the start edge and stays high for one clock. The results hold until the next start.
- R9: Synchronous active-high reset clears `taken`, `done`, `foreign`, `next_pc` and the counter. A reset during a count means no `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample inputs and begin resolution |
| prefix_sp | input | 1 | Stack-form prefix was fetched |
| opcode | input | 8 | Branch opcode |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_i | input | 1 | Interrupt mask flag |
| irq_level | input | 1 | Level of the interrupt-request pin |
| rel_off | input | 8 | Signed displacement |
| pc_in | input | 16 | Program counter of the instruction |
| reg_a | input | 8 | Accumulator |
| reg_x | input | 8 | Index register low byte |
| mem_byte | input | 8 | Memory or immediate operand |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Resolved next program counter |
| ret_addr | output | 16 | Fall-through address for the stack logic |
| cycle_count | output | 3 | Cycle cost of the instruction |
| foreign | output | 1 | Opcode not owned by this block |
| done | output | 1 | One-clock completion strobe |

## Verification
The bench drives backward displacements, including -128, and a target that wraps past 0xFFFF. A design that zero-extends the offset, or that does not wrap, would produce a wrong `next_pc`.

It places bit-test operands so that only the chosen bit decides the result. Swapping the set/clear sense or misreading opcode[3:1] would flip `taken`.

The compare with X uses an accumulator value that would match if the registers were swapped. The prefixed and plain forms of 0x61 are compared for step and cycle cost. A prefixed plain branch checks that the prefix does not slip through as a normal branch.

A reset in the middle of a count checks that no stale `done` strobe follows.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_REL,
      CLS_BIT,
      CLS_CMP,
      CLS_BSR
   } br_class_e;

   typedef struct packed {
      br_class_e  cls;
      logic [2:0] step;    // bytes from PC to fall-through address
      logic [2:0] cyc;     // cycle cost
      logic       use_x;   // compare against index register
   } br_decode_t;

endpackage

// File: rtl/br_decode.sv
module br_decode
   import branch_resolve_pkg::*;
(
   input  logic       prefix_sp,
   input  logic [7:0] opcode,
   output br_decode_t dec
);

   always_comb begin
      dec = '{cls: CLS_NONE, step: 3'd0, cyc: 3'd1, use_x: 1'b0};
      if (prefix_sp) begin
         if (opcode == 8'h61)
            dec = '{cls: CLS_CMP, step: 3'd4, cyc: 3'd6, use_x: 1'b0};
      end else if (opcode[7:4] == 4'h0) begin
         dec = '{cls: CLS_BIT, step: 3'd3, cyc: 3'd5, use_x: 1'b0};
      end else if (opcode[7:4] == 4'h2) begin
         if (!(opcode[3:0] inside {4'h2, 4'h7, 4'h8, 4'h9}))
            dec = '{cls: CLS_REL, step: 3'd2, cyc: 3'd3, use_x: 1'b0};
      end else begin
         case (opcode)
            8'h91, 8'h93: dec = '{cls: CLS_REL, step: 3'd2, cyc: 3'd3, use_x: 1'b0};
            8'h31:        dec = '{cls: CLS_CMP, step: 3'd3, cyc: 3'd5, use_x: 1'b0};
            8'h41:        dec = '{cls: CLS_CMP, step: 3'd3, cyc: 3'd4, use_x: 1'b0};
            8'h51:        dec = '{cls: CLS_CMP, step: 3'd3, cyc: 3'd4, use_x: 1'b1};
            8'h61:        dec = '{cls: CLS_CMP, step: 3'd3, cyc: 3'd5, use_x: 1'b0};
            8'h71:        dec = '{cls: CLS_CMP, step: 3'd2, cyc: 3'd4, use_x: 1'b0};
            8'hAD:        dec = '{cls: CLS_BSR, step: 3'd2, cyc: 3'd4, use_x: 1'b0};
            default:      ;
         endcase
      end
   end

endmodule

// File: rtl/br_cond.sv
module br_cond
   import branch_resolve_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  br_decode_t        dec,
   input  logic [7:0]        opcode,
   input  logic              fn,
   input  logic              fz,
   input  logic              fv,
   input  logic              fc,
   input  logic              fi,
   input  logic              irq,
   input  logic [DATA_W-1:0] ra,
   input  logic [DATA_W-1:0] rx,
   input  logic [DATA_W-1:0] mem,
   output logic              cond
);

   localparam int NBITS = 8;   // bit index field is opcode[3:1]

   logic [NBITS-1:0] bit_hit;
   logic             sel_bit;
   logic             rel_cond;

   for (genvar g = 0; g < NBITS; g++) begin : g_bitsel
      assign bit_hit[g] = (opcode[3:1] == 3'(g)) & mem[g];
   end
   assign sel_bit = |bit_hit;

   always_comb begin
      rel_cond = 1'b0;
      if (opcode == 8'h91)      rel_cond = fn ^ fv;
      else if (opcode == 8'h93) rel_cond = fz | (fn ^ fv);
      else begin
         case (opcode[3:0])
            4'h0: rel_cond = 1'b1;
            4'h1: rel_cond = 1'b0;
            4'h3: rel_cond = fc | fz;
            4'h4: rel_cond = ~fc;
            4'h5: rel_cond = fc;
            4'h6: rel_cond = ~fz;
            4'hA: rel_cond = ~fn;
            4'hB: rel_cond = fn;
            4'hC: rel_cond = ~fi;
            4'hD: rel_cond = fi;
            4'hE: rel_cond = ~irq;
            4'hF: rel_cond = irq;
            default: rel_cond = 1'b0;
         endcase
      end
   end

   always_comb begin
      case (dec.cls)
         CLS_REL: cond = rel_cond;
         CLS_BIT: cond = opcode[0] ? ~sel_bit : sel_bit;
         CLS_CMP: cond = ((dec.use_x ? rx : ra) == mem);
         CLS_BSR: cond = 1'b1;
         default: cond = 1'b0;
      endcase
   end

endmodule

// File: rtl/br_target.sv
module br_target #(
   parameter int PC_W  = 16,
   parameter int OFF_W = 8
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [2:0]       step,
   input  logic [OFF_W-1:0] off,
   input  logic             take,
   output logic [PC_W-1:0]  fall,
   output logic [PC_W-1:0]  next
);

   localparam int EXT_W = PC_W - OFF_W;

   logic [PC_W-1:0] off_ext;

   assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
   assign fall    = pc + PC_W'(step);
   assign next    = take ? (fall + off_ext) : fall;

endmodule

// File: rtl/br_count.sv
module br_count #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (load) begin
         cnt  <= load_val;
         done <= 1'b0;
      end else if (cnt != '0) begin
         cnt  <= cnt - 1'b1;
         done <= (cnt == CNT_W'(1));
      end else begin
         done <= 1'b0;
      end
   end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
   import branch_resolve_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PC_W   = 16,
   parameter int OFF_W  = 8,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              prefix_sp,
   input  logic [7:0]        opcode,
   input  logic              flag_n,
   input  logic              flag_z,
   input  logic              flag_v,
   input  logic              flag_c,
   input  logic              flag_i,
   input  logic              irq_level,
   input  logic [OFF_W-1:0]  rel_off,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_x,
   input  logic [DATA_W-1:0] mem_byte,
   output logic              taken,
   output logic [PC_W-1:0]   next_pc,
   output logic [PC_W-1:0]   ret_addr,
   output logic [CNT_W-1:0]  cycle_count,
   output logic              foreign,
   output logic              done
);

   if (DATA_W < 8) begin : g_chk_data
      $error("DATA_W must cover the 8 bit-test positions");
   end
   if (PC_W <= OFF_W) begin : g_chk_pc
      $error("PC_W must exceed OFF_W");
   end
   if (CNT_W < 3) begin : g_chk_cnt
      $error("CNT_W must hold a cost of 6");
   end

   br_decode_t      dec;
   logic            cond;
   logic            owned;
   logic [PC_W-1:0] fall_pc;
   logic [PC_W-1:0] tgt_pc;

   assign owned = (dec.cls != CLS_NONE);

   br_decode u_dec (
      .prefix_sp (prefix_sp),
      .opcode    (opcode),
      .dec       (dec)
   );

   br_cond #(.DATA_W(DATA_W)) u_cond (
      .dec    (dec),
      .opcode (opcode),
      .fn     (flag_n),
      .fz     (flag_z),
      .fv     (flag_v),
      .fc     (flag_c),
      .fi     (flag_i),
      .irq    (irq_level),
      .ra     (reg_a),
      .rx     (reg_x),
      .mem    (mem_byte),
      .cond   (cond)
   );

   br_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
      .pc   (pc_in),
      .step (dec.step),
      .off  (rel_off),
      .take (cond & owned),
      .fall (fall_pc),
      .next (tgt_pc)
   );

   br_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (start),
      .load_val (CNT_W'(dec.cyc)),
      .done     (done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         taken       <= 1'b0;
         next_pc     <= '0;
         ret_addr    <= '0;
         cycle_count <= '0;
         foreign     <= 1'b0;
      end else if (start) begin
         taken       <= cond & owned;
         next_pc     <= tgt_pc;
         ret_addr    <= fall_pc;
         cycle_count <= CNT_W'(dec.cyc);
         foreign     <= ~owned;
      end
   end

endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
   parameter int PC_W  = 16,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic             prefix_sp,
   input logic [7:0]       opcode,
   input logic [PC_W-1:0]  pc_in,
   input logic             taken,
   input logic [PC_W-1:0]  next_pc,
   input logic [PC_W-1:0]  ret_addr,
   input logic [CNT_W-1:0] cycle_count,
   input logic             foreign,
   input logic             done
);

   a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !start |=> ($stable(next_pc) && $stable(taken) && $stable(cycle_count)));

   a_r7_foreign_not_taken: assert property (@(posedge clk) disable iff (rst)
      foreign |-> !taken);

   a_r2_rel_cost: assert property (@(posedge clk) disable iff (rst)
      (start && !prefix_sp && opcode[7:4] == 4'h2 && !(opcode[3:0] inside {4'h2, 4'h7, 4'h8, 4'h9}))
      |=> (cycle_count == CNT_W'(3)));

   a_r3_bit_cost: assert property (@(posedge clk) disable iff (rst)
      (start && !prefix_sp && opcode[7:4] == 4'h0) |=> (cycle_count == CNT_W'(5)));

   a_r6_bsr_ret: assert property (@(posedge clk) disable iff (rst)
      (start && !prefix_sp && opcode == 8'hAD)
      |=> (taken && ret_addr == $past(pc_in) + PC_W'(2)));

   a_r9_reset_clears: assert property (@(posedge clk)
      rst |=> (!done && !taken && !foreign));

endmodule

bind branch_resolve branch_resolve_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .start       (start),
   .prefix_sp   (prefix_sp),
   .opcode      (opcode),
   .pc_in       (pc_in),
   .taken       (taken),
   .next_pc     (next_pc),
   .ret_addr    (ret_addr),
   .cycle_count (cycle_count),
   .foreign     (foreign),
   .done        (done)
);

// File: tb/branch_resolve_tb_top.sv
`timescale 1ns/1ps
module branch_resolve_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        prefix_sp = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic        flag_n = 0, flag_z = 0, flag_v = 0, flag_c = 0, flag_i = 0;
   logic        irq_level = 1'b0;
   logic [7:0]  rel_off = 8'h00;
   logic [15:0] pc_in = 16'h0000;
   logic [7:0]  reg_a = 8'h00, reg_x = 8'h00, mem_byte = 8'h00;
   logic        taken;
   logic [15:0] next_pc;
   logic [15:0] ret_addr;
   logic [2:0]  cycle_count;
   logic        foreign;
   logic        done;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   branch_resolve dut_i (
      .clk(clk), .rst(rst), .start(start), .prefix_sp(prefix_sp), .opcode(opcode),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .flag_i(flag_i),
      .irq_level(irq_level), .rel_off(rel_off), .pc_in(pc_in), .reg_a(reg_a),
      .reg_x(reg_x), .mem_byte(mem_byte), .taken(taken), .next_pc(next_pc),
      .ret_addr(ret_addr), .cycle_count(cycle_count), .foreign(foreign), .done(done)
   );

   typedef struct packed {
      logic        pfx;
      logic [7:0]  op;
      logic [4:0]  fl;    // n z v c i
      logic        irq;
      logic [7:0]  off;
      logic [15:0] pc;
      logic [7:0]  a;
      logic [7:0]  x;
      logic [7:0]  m;
      logic        tk;
      logic [15:0] npc;
      logic [2:0]  cyc;
      logic        fr;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h20, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b1, 16'h1012, 3'd3, 1'b0}, // R1 R2 always
      '{1'b0, 8'h21, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h1002, 3'd3, 1'b0}, // R1 never
      '{1'b0, 8'h23, 5'b01000, 1'b0, 8'hFE, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b1, 16'h1000, 3'd3, 1'b0}, // R1 C|Z, back -2
      '{1'b0, 8'h24, 5'b00010, 1'b0, 8'h10, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h1002, 3'd3, 1'b0}, // R1 C=0 fails
      '{1'b0, 8'h25, 5'b00010, 1'b0, 8'h08, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b1, 16'h100A, 3'd3, 1'b0}, // R1 C=1
      '{1'b0, 8'h26, 5'b00000, 1'b0, 8'h80, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0F82, 3'd3, 1'b0}, // R2 -128
      '{1'b0, 8'h2A, 5'b00000, 1'b0, 8'h01, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b1, 16'h1003, 3'd3, 1'b0}, // R1 N=0
      '{1'b0, 8'h2B, 5'b00000, 1'b0, 8'h01, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h1002, 3'd3, 1'b0}, // R1 N=1 fails
      '{1'b0, 8'h2D, 5'b00001, 1'b0, 8'h05, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b1, 16'h1007, 3'd3, 1'b0}, // R1 I=1
      '{1'b0, 8'h2C, 5'b00001, 1'b0, 8'h05, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h1002, 3'd3, 1'b0}, // R1 I=0 fails
      '{1'b0, 8'h2E, 5'b00000, 1'b1, 8'h04, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h1002, 3'd3, 1'b0}, // R1 pin low fails
      '{1'b0, 8'h2F, 5'b00000, 1'b1, 8'h04, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b1, 16'h1006, 3'd3, 1'b0}, // R1 pin high
      '{1'b0, 8'h91, 5'b10100, 1'b0, 8'h20, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h1002, 3'd3, 1'b0}, // R1 N^V=0
      '{1'b0, 8'h93, 5'b10000, 1'b0, 8'h20, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b1, 16'h1022, 3'd3, 1'b0}, // R1 Z|(N^V)
      '{1'b0, 8'h20, 5'b00000, 1'b0, 8'h7F, 16'hFFF0, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0071, 3'd3, 1'b0}, // R2 wrap
      '{1'b0, 8'h06, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h00, 8'h00, 8'h08, 1'b1, 16'h1013, 3'd5, 1'b0}, // R3 bit3 set
      '{1'b0, 8'h0F, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h00, 8'h00, 8'h80, 1'b0, 16'h1003, 3'd5, 1'b0}, // R3 bit7 clear fails
      '{1'b0, 8'h31, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h55, 8'h00, 8'h55, 1'b1, 16'h1013, 3'd5, 1'b0}, // R4 direct
      '{1'b0, 8'h41, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h10, 8'h11, 8'h11, 1'b0, 16'h1003, 3'd4, 1'b0}, // R4 imm A ne
      '{1'b0, 8'h51, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h55, 8'h33, 8'h55, 1'b0, 16'h1003, 3'd4, 1'b0}, // R4 X used
      '{1'b0, 8'h71, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h07, 8'h00, 8'h07, 1'b1, 16'h1012, 3'd4, 1'b0}, // R4 step 2
      '{1'b1, 8'h61, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h09, 8'h00, 8'h09, 1'b1, 16'h1014, 3'd6, 1'b0}, // R5 stack form
      '{1'b0, 8'h61, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h09, 8'h00, 8'h09, 1'b1, 16'h1013, 3'd5, 1'b0}, // R4 plain 0x61
      '{1'b0, 8'h22, 5'b01000, 1'b0, 8'h10, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h1000, 3'd1, 1'b1}  // R7 foreign
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic issue(input vec_t v);
      @(negedge clk);
      prefix_sp = v.pfx; opcode = v.op;
      {flag_n, flag_z, flag_v, flag_c, flag_i} = v.fl;
      irq_level = v.irq; rel_off = v.off; pc_in = v.pc;
      reg_a = v.a; reg_x = v.x; mem_byte = v.m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int n;
      issue(v);
      check($sformatf("R1 taken vec%0d", idx), 32'(taken), 32'(v.tk));
      check($sformatf("R2 next_pc vec%0d", idx), 32'(next_pc), 32'(v.npc));
      check($sformatf("R4 cycle_count vec%0d", idx), 32'(cycle_count), 32'(v.cyc));
      check($sformatf("R7 foreign vec%0d", idx), 32'(foreign), 32'(v.fr));
      n = 0;
      while (!done && n < 20) begin
         @(negedge clk);
         n++;
      end
      check($sformatf("R8 done delay vec%0d", idx), 32'(n), 32'(v.cyc));
      @(negedge clk);
      check($sformatf("R8 done width vec%0d", idx), 32'(done), 32'd0);
      check($sformatf("R8 hold vec%0d", idx), 32'(next_pc), 32'(v.npc));
   endtask

   initial begin : watchdog
      #100us;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      vec_t v;
      int   seen;
      repeat (3) @(negedge clk);
      check("R9 reset taken", 32'(taken), 32'd0);
      check("R9 reset done", 32'(done), 32'd0);
      check("R9 reset foreign", 32'(foreign), 32'd0);
      check("R9 reset next_pc", 32'(next_pc), 32'd0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

      // R6: subroutine branch, always taken, return address PC+2
      v = '{1'b0, 8'hAD, 5'b11111, 1'b0, 8'h10, 16'h2000, 8'h00, 8'h00, 8'h00, 1'b1, 16'h2012, 3'd4, 1'b0};
      run_vec(v, 100);
      check("R6 ret_addr", 32'(ret_addr), 32'h2002);

      // R5: prefix on a plain branch is foreign
      v = '{1'b1, 8'h20, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h00, 8'h00, 8'h00, 1'b0, 16'h1000, 3'd1, 1'b1};
      run_vec(v, 101);

      // R3: bit0 set form with only bit0 high
      v = '{1'b0, 8'h00, 5'b00000, 1'b0, 8'hF0, 16'h1000, 8'h00, 8'h00, 8'h01, 1'b1, 16'h0FF3, 3'd5, 1'b0};
      run_vec(v, 102);

      // R9: reset during a count suppresses done
      v = '{1'b1, 8'h61, 5'b00000, 1'b0, 8'h10, 16'h1000, 8'h09, 8'h00, 8'h09, 1'b1, 16'h1014, 3'd6, 1'b0};
      issue(v);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R9 taken cleared", 32'(taken), 32'd0);
      seen = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (done) seen++;
      end
      check("R9 no stale done", 32'(seen), 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule